// File: doc/BRIEF.md
# I2C master bus command sequencer

This block is a byte-level I2C master. Software reaches it through a small register port of four 8-bit registers. A write to the control register sets the enable bit and issues one bus command: a first START, a repeated START, a STOP, or nothing. A write to the data register sends one byte on the bus and samples the slave's acknowledge bit. Every bus action is cut into quarter-SCL-period steps. A divider sets the length of one quarter in core clock cycles.

When a command or a byte finishes, the block sets a sticky done flag, which software clears by writing 1 to it. The acknowledge result of the last byte reads back from bit 3 of the control register. On a write, the same bit selects between a first START and a repeated START. Both bus lines are open-drain outputs: each pin asks for the line to be pulled low. A pad-release bit overrides the sequencer and lets both lines float.

The register port is a plain one-cycle write strobe with a combinational read. It has no valid/ready handshake and no back-pressure. Software learns when the block can accept the next command by polling the busy bit.

Top module: `i2c_cmd_seq`

Register addresses (`reg_addr`): 0 = control, 1 = status, 2 = data, 3 = pad control.

## Requirements
- R1: After reset, control reads 0x00, status reads 0x00 and pad control reads 0x04 (lines released), and neither line is pulled low.
- R2: Control bit 0 is enable and bits 2:1 are the command (0 none, 1 START/repeated START, 2 STOP). A command runs only when the same write sets bit 0. A data write while enable is 0 starts nothing. Bits 2:0 read back as written.
- R3: A START command written with control bit 3 = 0 makes a first START lasting 3 quarters. Written with bit 3 = 1, it makes a repeated START lasting 4 quarters: SDA is released, then SCL, and then SDA falls while SCL is high.
- R4: A data write shifts the byte out MSB first on 8 SCL pulses and releases SDA for a ninth pulse. SDA is sampled in the high phase of that ninth pulse. Control bit 3 then reads 1 for NAK and 0 for ACK.
- R5: Status bit 3 (done) is set when any command or byte finishes. Writing 1 to a status bit clears only that bit.
- R6: Status bit 7 (busy) is high from the cycle after a launching write until completion. A byte keeps it high for 36 quarters, and each quarter lasts QDIV clock cycles.
- R7: A data write while busy is ignored: the byte on the bus is the first one. Such a write sets status bit 2 (error).
- R8: Status bits 6 and 5 always read as zero.
- R9: While pad control bit 2 is 1, neither line is pulled low, whatever the sequencer state. Clearing the bit exposes the held line state.
- R10: A STOP pulls SDA low, releases SCL one quarter later, and releases SDA one quarter after that. It lasts 3 quarters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with QDIV = 2, so a quarter is two clock cycles and a full byte keeps the block busy for 72 cycles. With quarters this short, the busy window of every command can be counted exactly. The quarter spacing of the STOP edges can be measured from the wire. Many bytes with both ACK and NAK from a modelled slave fit in a short run. The default value of 125 is larger only in the divider count and adds no further structure.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int REG_W  = 8;
  localparam int BYTE_W = 8;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_PAD  = 2'd3;

  localparam logic [1:0] CMD_NONE  = 2'd0;
  localparam logic [1:0] CMD_START = 2'd1;
  localparam logic [1:0] CMD_STOP  = 2'd2;

  localparam logic [REG_W-1:0] STAT_RSVD = 8'h60;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_STOP    = 2'd2,
    OP_BYTE    = 2'd3
  } bus_op_e;

  // index of the final quarter step of each operation
  function automatic logic [5:0] op_last(input bus_op_e op);
    case (op)
      OP_START:   op_last = 6'd2;
      OP_RESTART: op_last = 6'd3;
      OP_STOP:    op_last = 6'd2;
      default:    op_last = 6'(4 * (BYTE_W + 1) - 1);
    endcase
  endfunction

  // line levels {sda, scl} during a quarter step, 1 = released
  function automatic logic [1:0] op_levels(input bus_op_e op, input logic [5:0] st,
                                           input logic [BYTE_W-1:0] d);
    logic [3:0] bitn;
    logic [1:0] qtr;
    logic       sda;
    bitn = st[5:2];
    qtr  = st[1:0];
    case (op)
      OP_START: begin
        case (st)
          6'd0:    op_levels = 2'b11;
          6'd1:    op_levels = 2'b01;
          default: op_levels = 2'b00;
        endcase
      end
      OP_RESTART: begin
        case (st)
          6'd0:    op_levels = 2'b10;
          6'd1:    op_levels = 2'b11;
          6'd2:    op_levels = 2'b01;
          default: op_levels = 2'b00;
        endcase
      end
      OP_STOP: begin
        case (st)
          6'd0:    op_levels = 2'b00;
          6'd1:    op_levels = 2'b01;
          default: op_levels = 2'b11;
        endcase
      end
      default: begin
        sda = (bitn < 4'(BYTE_W)) ? d[3'(BYTE_W - 1) - bitn[2:0]] : 1'b1;
        op_levels = {sda, (qtr == 2'd1) || (qtr == 2'd2)};
      end
    endcase
  endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QDIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  bus_op_e           launch_op,
  input  logic [BYTE_W-1:0] launch_data,
  input  logic              tick,
  input  logic              sda_in,
  output logic              active,
  output logic              done,
  output logic              nak,
  output logic              sda_lvl,
  output logic              scl_lvl
);
  localparam logic [5:0] ACK_STEP = 6'(4 * BYTE_W + 2);

  bus_op_e           op;
  logic [5:0]        step;
  logic [BYTE_W-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      done    <= 1'b0;
      nak     <= 1'b0;
      op      <= OP_START;
      step    <= '0;
      data    <= '0;
      sda_lvl <= 1'b1;
      scl_lvl <= 1'b1;
    end else begin
      done <= 1'b0;
      if (launch && !active) begin
        active             <= 1'b1;
        op                 <= launch_op;
        data               <= launch_data;
        step               <= '0;
        {sda_lvl, scl_lvl} <= op_levels(launch_op, 6'd0, launch_data);
      end else if (active && tick) begin
        if (op == OP_BYTE && step == ACK_STEP) nak <= sda_in;
        if (step == op_last(op)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          step               <= step + 6'd1;
          {sda_lvl, scl_lvl} <= op_levels(op, step + 6'd1, data);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regs.sv
module i2c_regs
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              busy,
  input  logic              eng_done,
  input  logic              eng_nak,
  output logic              launch,
  output bus_op_e           launch_op,
  output logic [BYTE_W-1:0] launch_data,
  output logic              pad_off
);
  logic       en;
  logic [1:0] cmd;
  logic       done_f;
  logic       err_f;
  logic [BYTE_W-1:0] data_r;

  logic wr_ctrl, wr_stat, wr_data, wr_pad;
  assign wr_ctrl = wr && (addr == RA_CTRL);
  assign wr_stat = wr && (addr == RA_STAT);
  assign wr_data = wr && (addr == RA_DATA);
  assign wr_pad  = wr && (addr == RA_PAD);

  always_comb begin
    launch    = 1'b0;
    launch_op = OP_BYTE;
    if (!busy) begin
      if (wr_ctrl && wdata[0] && wdata[2:1] == CMD_START) begin
        launch    = 1'b1;
        launch_op = wdata[3] ? OP_RESTART : OP_START;
      end else if (wr_ctrl && wdata[0] && wdata[2:1] == CMD_STOP) begin
        launch    = 1'b1;
        launch_op = OP_STOP;
      end else if (wr_data && en) begin
        launch    = 1'b1;
        launch_op = OP_BYTE;
      end
    end
  end
  assign launch_data = wdata[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      cmd     <= CMD_NONE;
      done_f  <= 1'b0;
      err_f   <= 1'b0;
      data_r  <= '0;
      pad_off <= 1'b1;
    end else begin
      if (wr_ctrl && !busy) begin
        en  <= wdata[0];
        cmd <= wdata[2:1];
      end
      if (wr_data && !busy) data_r <= wdata[BYTE_W-1:0];
      if (wr_pad) pad_off <= wdata[2];
      done_f <= (done_f && !(wr_stat && wdata[3])) || eng_done;
      err_f  <= (err_f && !(wr_stat && wdata[2])) || (wr_data && busy);
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL: rdata = {4'b0, eng_nak, cmd, en};
      RA_STAT: rdata = {busy, 3'b0, done_f, err_f, 2'b0};
      RA_DATA: rdata = data_r;
      default: rdata = {5'b0, pad_off, 2'b0};
    endcase
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int QDIV = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sda_i,
  output logic       scl_pull_low,
  output logic       sda_pull_low
);
  logic              eng_active;
  logic              eng_done;
  logic              eng_nak;
  logic              qtick;
  logic              launch;
  bus_op_e           launch_op;
  logic [BYTE_W-1:0] launch_data;
  logic              pad_off;
  logic              sda_lvl, scl_lvl;

  i2c_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(eng_active), .eng_done(eng_done), .eng_nak(eng_nak),
    .launch(launch), .launch_op(launch_op), .launch_data(launch_data),
    .pad_off(pad_off)
  );

  i2c_qtick #(.QDIV(QDIV)) u_qtick (
    .clk(clk), .rst_n(rst_n), .run(eng_active), .tick(qtick)
  );

  i2c_bit_engine u_engine (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
    .launch_data(launch_data), .tick(qtick), .sda_in(sda_i),
    .active(eng_active), .done(eng_done), .nak(eng_nak),
    .sda_lvl(sda_lvl), .scl_lvl(scl_lvl)
  );

  assign scl_pull_low = !pad_off && !scl_lvl;
  assign sda_pull_low = !pad_off && !sda_lvl;
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       scl_pull_low,
  input logic       sda_pull_low,
  input logic       busy,
  input logic       eng_done
);
  assert_busy_write_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && busy) |=> (reg_addr != 2'd1 || reg_rdata[2]));

  assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (reg_addr != 2'd1 || reg_rdata[3]));

  assert_finish_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eng_done);

  assert_busy_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr));

  assert_pad_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && reg_wdata[2]) |=> (!scl_pull_low && !sda_pull_low));

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> ((reg_rdata & 8'h60) == 8'h00));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_pull_low(scl_pull_low),
  .sda_pull_low(sda_pull_low), .busy(eng_active), .eng_done(eng_done)
);

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
  localparam int CLK_P = 10;
  localparam int Q     = 2;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_PAD = 2'd3;
  // {slave acks, expected nak bit, byte}
  localparam logic [9:0] VEC [6] = '{
    {1'b1, 1'b0, 8'hA5}, {1'b0, 1'b1, 8'h3C}, {1'b1, 1'b0, 8'h80},
    {1'b0, 1'b1, 8'h01}, {1'b1, 1'b0, 8'hFF}, {1'b1, 1'b0, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl_pull_low, sda_pull_low;
  logic slv_pull = 1'b0, ack_en = 1'b0;
  wire  sda_line = !(sda_pull_low || slv_pull);
  wire  scl_line = !scl_pull_low;

  always #(CLK_P / 2) clk = ~clk;

  i2c_cmd_seq #(.QDIV(Q)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_i(sda_line),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave and line monitor
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] shreg = 8'h00, last_byte = 8'h00;
  int bitcnt = 0, byte_cnt = 0, start_cnt = 0, stop_cnt = 0;
  int t_sda_fall = 0, t_scl_rise = 0, t_stop = 0;
  always @(negedge clk) begin
    if (p_scl && scl_line && p_sda && !sda_line) begin start_cnt++; bitcnt = 0; end
    if (p_scl && scl_line && !p_sda && sda_line) begin stop_cnt++; bitcnt = 0; t_stop = cyc; end
    if (p_sda && !sda_line) t_sda_fall = cyc;
    if (!p_scl && scl_line) begin
      t_scl_rise = cyc;
      if (bitcnt < 8) shreg = {shreg[6:0], sda_line};
      bitcnt++;
      if (bitcnt == 8) begin last_byte = shreg; byte_cnt++; end
    end
    if (p_scl && !scl_line) begin
      if (bitcnt == 8) slv_pull = ack_en;
      else if (bitcnt == 9) begin slv_pull = 1'b0; bitcnt = 0; end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    reg_addr = A_STAT;
    #1;
    while (reg_rdata[7] && n < 5000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R6 watchdog actual=busy expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, bc, sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    rd(A_STAT, v); chk("R1 stat", v, 8'h00);
    rd(A_PAD, v);  chk("R1 pad", v, 8'h04);
    chk("R1 lines", {scl_pull_low, sda_pull_low}, 0);

    wr(A_PAD, 8'h00);
    wr(A_CTRL, 8'h02);
    wait_idle(n); chk("R2 disabled start", n, 0);
    chk("R2 no start on bus", start_cnt, 0);
    wr(A_DATA, 8'h55);
    wait_idle(n); chk("R2 disabled data", n, 0);
    rd(A_STAT, v); chk("R2 stat idle", v, 8'h00);

    wr(A_CTRL, 8'h03);
    wait_idle(n); chk("R3 first start quarters", n, 3 * Q);
    chk("R3 start seen", start_cnt, 1);
    rd(A_STAT, v); chk("R5 done set", v, 8'h08);
    wr(A_STAT, 8'h08);
    rd(A_STAT, v); chk("R5 done cleared", v, 8'h00);
    rd(A_CTRL, v); chk("R2 readback", v, 8'h03);

    for (int i = 0; i < 6; i++) begin
      ack_en = VEC[i][9];
      bc = byte_cnt;
      wr(A_DATA, VEC[i][7:0]);
      wait_idle(n); chk("R6 byte busy", n, 36 * Q);
      chk("R4 byte on bus", last_byte, VEC[i][7:0]);
      chk("R4 one byte", byte_cnt, bc + 1);
      rd(A_CTRL, v); chk("R4 nak bit", v[3], VEC[i][8]);
      rd(A_STAT, v); chk("R5 done after byte", v, 8'h08);
      wr(A_STAT, 8'h08);
    end

    ack_en = 1'b1;
    bc = byte_cnt;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = 8'hC3;
    @(negedge clk);
    reg_wdata = 8'h3C;
    @(negedge clk);
    reg_wr = 1'b0;
    wait_idle(n);
    chk("R7 first byte kept", last_byte, 8'hC3);
    chk("R7 single byte", byte_cnt, bc + 1);
    rd(A_STAT, v); chk("R7 err and done", v, 8'h0C);
    wr(A_STAT, 8'h04);
    rd(A_STAT, v); chk("R5 selective clear", v, 8'h08);
    wr(A_STAT, 8'h08);

    sc = start_cnt;
    wr(A_CTRL, 8'h0B);
    wait_idle(n); chk("R3 restart quarters", n, 4 * Q);
    chk("R3 restart seen", start_cnt, sc + 1);
    wr(A_DATA, 8'h96);
    wait_idle(n); chk("R4 byte after restart", last_byte, 8'h96);
    wr(A_STAT, 8'h08);

    sc = stop_cnt;
    wr(A_CTRL, 8'h05);
    wait_idle(n); chk("R10 stop quarters", n, 3 * Q);
    chk("R10 stop seen", stop_cnt, sc + 1);
    chk("R10 scl after sda fall", t_scl_rise - t_sda_fall, Q);
    chk("R10 sda after scl", t_stop - t_scl_rise, Q);
    rd(A_CTRL, v); chk("R2 stop readback", v[2:0], 3'd5);
    rd(A_STAT, v); chk("R8 rsvd zero", v & 8'h60, 0);
    wr(A_STAT, 8'hFF);
    rd(A_STAT, v); chk("R8 all cleared", v, 8'h00);

    wr(A_PAD, 8'h04);
    sc = start_cnt;
    wr(A_CTRL, 8'h03);
    wait_idle(n); chk("R9 start ran", n, 3 * Q);
    chk("R9 lines released", {scl_pull_low, sda_pull_low}, 0);
    chk("R9 no start on bus", start_cnt, sc);
    wr(A_PAD, 8'h00);
    #1 chk("R9 held state exposed", {scl_pull_low, sda_pull_low}, 3);
    wr(A_CTRL, 8'h05);
    wait_idle(n); chk("R10 final stop", {scl_pull_low, sda_pull_low}, 0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule